// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block holds the current time of day and the calendar date as packed BCD bytes. A host reads and writes them through a small synchronous register port. A prescaler counts pulses on `tick_i`. Each full group of `TICKS_PER_SEC` pulses advances the time by one second. Carries ripple from seconds up to the century byte, and the month length follows the calendar, including the leap-February rule for a two-digit year.

The block also has a status byte with a two-step write guard. The host first sets the enable bit, and then sets the register-enable bit. Only with both bits set do writes to the time bytes take effect. The status byte also holds two sticky flags: one for an oscillator fault and one for power-up. The first accepted time write clears both flags. Day of week is a separate 0–6 counter that advances on every day carry. The top bit of the hour byte is a format-mode bit that the block keeps but does not count.

Top module: `rtcc_clock`

## Requirements
- R1: After a synchronous reset, seconds, minutes, hours, year and day of week read 00h. Date and month read 01h, the century byte reads 20h and status reads 01h.
- R2: Seconds advance by one on the clock edge that samples the `TICKS_PER_SEC`-th tick pulse since the last wrap or clear. Fewer pulses leave the time unchanged.
- R3: Seconds and minutes count 00–59 and wrap to 00 with a carry. Hours (bits 5:0) count 00–23 and wrap to 00 with a carry. Hour bit 7 is never changed by counting.
- R4: Date wraps to 01 and carries into the month after day 30 in months 04, 06, 09 and 11, and after day 31 in all other months except 02.
- R5: In month 02, the date wraps after 29 when the two-digit year is divisible by 4, and after 28 otherwise.
- R6: Month wraps from 12 to 01 and carries into the year. Year wraps from 99 to 00. On that year wrap, a century byte of 19h becomes 20h, and 20h stays 20h.
- R7: Day of week (address 6, bits 2:0) increments on every date carry and wraps from 6 to 0.
- R8: A write to addresses 0–7 takes effect only when status bits 1 and 2 are both set. Otherwise the write is ignored.
- R9: Status bit 1 takes `wdata_i[1]` on every status write (address 8). Status bit 2 takes `wdata_i[2]` only if bit 1 was already set before that write.
- R10: An accepted write to seconds (address 0) restarts the tick count, so `TICKS_PER_SEC` more pulses are needed for the next second.
- R11: Address map: 0 sec, 1 min, 2 hour, 3 date, 4 month, 5 year, 6 day of week, 7 century, 8 status. Other addresses read 00h. Unused bits are dropped on write and read as 0: sec/min bit 7, hour bit 6, date bits 7:6, month bits 7:5, day-of-week bits 7:3.
- R12: Status bit 4 is set while `osc_fail_i` is high. Status bit 0 is set by reset. Any accepted time write clears both bits. Status bits 7, 6, 5 and 3 read 0.
- R13: An accepted time write in the same cycle as a one-second step cancels that step. A day-of-week write of 7, or a century write other than 19h or 20h, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | Prescaler pulse, one clock wide |
| osc_fail_i | input | 1 | Oscillator fault indication |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register (combinational) |

## Verification
The in-line assertions check several rules on every cycle:
- seconds wrap from 59 and carry into minutes;
- hour bit 7 survives counting;
- the century advances on a 99-to-00 year wrap;
- day of week stays within 0–6;
- a locked write leaves the time untouched;
- the register-enable bit cannot change while the enable bit is clear;
- the prescaler restarts after a clear.

The bench scenarios cover the results that need a full setup:
- month-end wraps across 30-day, 31-day and both February lengths;
- the year and century wraps;
- the exact tick count per second;
- field masking;
- a write landing on a step.

// File: rtl/rtcc_pkg.sv
// Shared constants and BCD helper functions for the time/calendar counter.
// Assumes all stored fields hold valid packed BCD.
package rtcc_pkg;

    // Register addresses
    localparam int FA_SEC   = 0;
    localparam int FA_MIN   = 1;
    localparam int FA_HOUR  = 2;
    localparam int FA_DATE  = 3;
    localparam int FA_MONTH = 4;
    localparam int FA_YEAR  = 5;
    localparam int FA_DOW   = 6;
    localparam int FA_CENT  = 7;
    localparam int FA_STAT  = 8;

    // Writable-bit masks per field
    localparam logic [7:0] MSK_SEC   = 8'h7F;
    localparam logic [7:0] MSK_MIN   = 8'h7F;
    localparam logic [7:0] MSK_HOUR  = 8'hBF;
    localparam logic [7:0] MSK_DATE  = 8'h3F;
    localparam logic [7:0] MSK_MONTH = 8'h1F;
    localparam logic [7:0] MSK_DOW   = 8'h07;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] date;
        logic [7:0] month;
        logic [7:0] year;
        logic [7:0] dow;
        logic [7:0] cent;
    } rtcc_time_t;

    // Next packed-BCD value, units 9 carries into tens
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Two-digit BCD year divisible by four
    function automatic logic bcd_leap(input logic [7:0] y);
        if (!y[4])
            return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    endfunction

    // Last date of a BCD month in a BCD year
    function automatic logic [7:0] bcd_month_last(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtcc_prescaler.sv
// Tick prescaler: emits a one-second step when the last tick of a group
// arrives. A clear restarts the group and suppresses the step that cycle.
// Assumes tick_i pulses are one clock wide.
module rtcc_prescaler #(
    parameter int TICKS_PER_SEC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic clr_i,
    output logic step_o
);

    generate
        if (TICKS_PER_SEC <= 1) begin : g_direct
            // Every tick is a full second
            assign step_o = tick_i && !clr_i;
        end else begin : g_count
            localparam int CNT_W = $clog2(TICKS_PER_SEC);
            localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

            logic [CNT_W-1:0] cnt_q;

            assign step_o = tick_i && !clr_i && (cnt_q == LAST);

            // Count tick pulses within the current second
            always_ff @(posedge clk) begin
                if (!rst_n || clr_i)
                    cnt_q <= '0;
                else if (tick_i)
                    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end

            a_r10_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
                clr_i |=> (cnt_q == '0));
            a_r2_step_restarts: assert property (@(posedge clk) disable iff (!rst_n)
                step_o |=> (cnt_q == '0));
        end
    endgenerate

endmodule

// File: rtl/rtcc_status.sv
// Status byte: two-step write guard plus sticky oscillator-fault and
// power-up flags. Assumes time_acc_i marks an accepted time-field write.
module rtcc_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       st_wr_i,
    input  logic [7:0] wdata_i,
    input  logic       time_acc_i,
    input  logic       osc_fail_i,
    output logic       unlock_o,
    output logic [7:0] status_o
);

    logic wel_q, rwel_q, oscf_q, pwrf_q;

    // Guard bits: enable always writable, register-enable only once enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_q  <= 1'b0;
            rwel_q <= 1'b0;
        end else if (st_wr_i) begin
            wel_q <= wdata_i[1];
            if (wel_q)
                rwel_q <= wdata_i[2];
        end
    end

    // Sticky flags: set by fault or reset, cleared by an accepted time write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oscf_q <= 1'b0;
            pwrf_q <= 1'b1;
        end else begin
            if (osc_fail_i)
                oscf_q <= 1'b1;
            else if (time_acc_i)
                oscf_q <= 1'b0;
            if (time_acc_i)
                pwrf_q <= 1'b0;
        end
    end

    assign unlock_o = wel_q && rwel_q;
    assign status_o = {3'b000, oscf_q, 1'b0, rwel_q, wel_q, pwrf_q};

    a_r9_rwel_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr_i && !status_o[1]) |=> (status_o[2] == $past(status_o[2])));
    a_r12_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (time_acc_i && !osc_fail_i) |=> (status_o[0] == 1'b0 && status_o[4] == 1'b0));

endmodule

// File: rtl/rtcc_calendar.sv
// Calendar counter: holds all BCD time fields, applies accepted host
// writes and otherwise advances one second per step with the full carry
// chain. Assumes written values are valid BCD within each field's range.
module rtcc_calendar
    import rtcc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output rtcc_time_t        time_o
);

    rtcc_time_t t_q;
    logic c_min, c_hour, c_day, c_mon, c_year, c_cent;

    // Carry chain across fields at their range limits
    always_comb begin
        c_min  = (t_q.sec == 8'h59);
        c_hour = c_min  && (t_q.min == 8'h59);
        c_day  = c_hour && (t_q.hour[5:0] == 6'h23);
        c_mon  = c_day  && (t_q.date == bcd_month_last(t_q.month, t_q.year));
        c_year = c_mon  && (t_q.month == 8'h12);
        c_cent = c_year && (t_q.year == 8'h99);
    end

    // Field registers: host write wins, else advance on step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, date: 8'h01,
                     month: 8'h01, year: 8'h00, dow: 8'h00, cent: 8'h20};
        end else if (wr_i) begin
            case (addr_i)
                ADDR_W'(FA_SEC):   t_q.sec   <= wdata_i & MSK_SEC;
                ADDR_W'(FA_MIN):   t_q.min   <= wdata_i & MSK_MIN;
                ADDR_W'(FA_HOUR):  t_q.hour  <= wdata_i & MSK_HOUR;
                ADDR_W'(FA_DATE):  t_q.date  <= wdata_i & MSK_DATE;
                ADDR_W'(FA_MONTH): t_q.month <= wdata_i & MSK_MONTH;
                ADDR_W'(FA_YEAR):  t_q.year  <= wdata_i;
                ADDR_W'(FA_DOW):
                    if ((wdata_i & MSK_DOW) != 8'h07)
                        t_q.dow <= wdata_i & MSK_DOW;
                ADDR_W'(FA_CENT):
                    if (wdata_i == 8'h19 || wdata_i == 8'h20)
                        t_q.cent <= wdata_i;
                default: ;
            endcase
        end else if (step_i) begin
            t_q.sec <= c_min ? 8'h00 : bcd_inc(t_q.sec);
            if (c_min)
                t_q.min <= (t_q.min == 8'h59) ? 8'h00 : bcd_inc(t_q.min);
            if (c_hour)
                t_q.hour <= c_day ? {t_q.hour[7], 7'h00}
                                  : {t_q.hour[7], 1'b0, bcd_inc({2'b00, t_q.hour[5:0]})[5:0]};
            if (c_day) begin
                t_q.date <= c_mon ? 8'h01 : bcd_inc(t_q.date);
                t_q.dow  <= (t_q.dow == 8'h06) ? 8'h00 : t_q.dow + 8'h01;
            end
            if (c_mon)
                t_q.month <= c_year ? 8'h01 : bcd_inc(t_q.month);
            if (c_year)
                t_q.year <= c_cent ? 8'h00 : bcd_inc(t_q.year);
            if (c_cent && t_q.cent == 8'h19)
                t_q.cent <= 8'h20;
        end
    end

    assign time_o = t_q;

    a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !wr_i && t_q.sec == 8'h59) |=>
            (t_q.sec == 8'h00 && t_q.min != $past(t_q.min)));
    a_r3_hour_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !wr_i) |=> (t_q.hour[7] == $past(t_q.hour[7])));
    a_r6_century_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !wr_i && t_q.year == 8'h99 && t_q.cent == 8'h19 && t_q.month == 8'h12
         && t_q.date == 8'h31 && t_q.hour[5:0] == 6'h23 && t_q.min == 8'h59 && t_q.sec == 8'h59)
            |=> (t_q.cent == 8'h20 && t_q.year == 8'h00));
    a_r7_dow_range: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.dow <= 8'h06);

endmodule

// File: rtl/rtcc_clock.sv
// Top of the BCD time/calendar counter: decodes the host port, gates time
// writes with the status guard, and muxes the read data. Assumes tick_i is
// a one-clock pulse and that the host writes valid BCD values.
module rtcc_clock
    import rtcc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 4,
    parameter int ADDR_W        = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              osc_fail_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o
);

    logic       wr_time, time_acc, sec_clr, st_wr, step, unlock;
    logic [7:0] status;
    rtcc_time_t tm;

    // Host write decode and guard
    assign wr_time  = wr_en_i && (addr_i <= ADDR_W'(FA_CENT));
    assign time_acc = wr_time && unlock;
    assign sec_clr  = time_acc && (addr_i == ADDR_W'(FA_SEC));
    assign st_wr    = wr_en_i && (addr_i == ADDR_W'(FA_STAT));

    rtcc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) presc_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .clr_i(sec_clr), .step_o(step)
    );

    rtcc_status status_i (
        .clk(clk), .rst_n(rst_n), .st_wr_i(st_wr), .wdata_i(wdata_i),
        .time_acc_i(time_acc), .osc_fail_i(osc_fail_i),
        .unlock_o(unlock), .status_o(status)
    );

    rtcc_calendar #(.ADDR_W(ADDR_W)) cal_i (
        .clk(clk), .rst_n(rst_n), .step_i(step), .wr_i(time_acc),
        .addr_i(addr_i), .wdata_i(wdata_i), .time_o(tm)
    );

    // Read mux over the register map
    always_comb begin
        case (addr_i)
            ADDR_W'(FA_SEC):   rdata_o = tm.sec;
            ADDR_W'(FA_MIN):   rdata_o = tm.min;
            ADDR_W'(FA_HOUR):  rdata_o = tm.hour;
            ADDR_W'(FA_DATE):  rdata_o = tm.date;
            ADDR_W'(FA_MONTH): rdata_o = tm.month;
            ADDR_W'(FA_YEAR):  rdata_o = tm.year;
            ADDR_W'(FA_DOW):   rdata_o = tm.dow;
            ADDR_W'(FA_CENT):  rdata_o = tm.cent;
            ADDR_W'(FA_STAT):  rdata_o = status;
            default:           rdata_o = 8'h00;
        endcase
    end

    a_r8_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_time && !unlock && !step) |=> $stable(tm));

endmodule

// File: tb/rtcc_clock_tb_top.sv
module rtcc_clock_tb_top;

    localparam int TPS  = 4;
    localparam int NVEC = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       osc_fail_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [3:0] addr_i = '0;
    logic [7:0] wdata_i = '0;
    logic [7:0] rdata_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rtcc_clock #(.TICKS_PER_SEC(TPS), .ADDR_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .osc_fail_i(osc_fail_i),
        .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
    );

    // Start values {sec,min,hour,date,month,year,dow,cent}, then expected after one second
    localparam logic [127:0] VEC [NVEC] = '{
        {64'h56_34_12_15_06_24_03_20, 64'h57_34_12_15_06_24_03_20}, // R3 plain second
        {64'h59_34_12_15_06_24_03_20, 64'h00_35_12_15_06_24_03_20}, // R3 minute carry
        {64'h59_59_12_15_06_24_03_20, 64'h00_00_13_15_06_24_03_20}, // R3 hour carry
        {64'h59_59_A3_15_06_24_03_20, 64'h00_00_80_16_06_24_04_20}, // R3 R7 day, mode bit
        {64'h59_59_23_30_04_24_06_20, 64'h00_00_00_01_05_24_00_20}, // R4 R7 30-day month
        {64'h59_59_23_31_01_24_01_20, 64'h00_00_00_01_02_24_02_20}, // R4 31-day month
        {64'h59_59_23_30_01_24_01_20, 64'h00_00_00_31_01_24_02_20}, // R4 no wrap at 30
        {64'h59_59_23_28_02_23_02_20, 64'h00_00_00_01_03_23_03_20}, // R5 non-leap Feb
        {64'h59_59_23_28_02_24_02_20, 64'h00_00_00_29_02_24_03_20}, // R5 leap Feb 28
        {64'h59_59_23_29_02_24_02_20, 64'h00_00_00_01_03_24_03_20}, // R5 leap Feb 29
        {64'h59_59_23_28_02_00_05_20, 64'h00_00_00_29_02_00_06_20}, // R5 year 00 leap
        {64'h59_59_23_28_02_12_05_20, 64'h00_00_00_29_02_12_06_20}, // R5 year 12 leap
        {64'h59_59_23_28_02_10_05_20, 64'h00_00_00_01_03_10_06_20}, // R5 year 10 not leap
        {64'h59_59_23_31_12_23_04_20, 64'h00_00_00_01_01_24_05_20}, // R6 year end
        {64'h59_59_23_31_12_99_04_19, 64'h00_00_00_01_01_00_05_20}, // R6 century advance
        {64'h59_59_23_30_09_99_04_20, 64'h00_00_00_01_10_99_05_20}  // R4 Sep to Oct
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp_v);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr_i = a;
        #1 d = rdata_o;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
        end
    endtask

    task automatic rchk(input string req, input logic [3:0] a, input logic [7:0] exp_v);
        logic [7:0] d;
        rd(a, d);
        check(req, d, exp_v);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] st, ex;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rchk("R1", 4'd0, 8'h00); rchk("R1", 4'd1, 8'h00); rchk("R1", 4'd2, 8'h00);
        rchk("R1", 4'd3, 8'h01); rchk("R1", 4'd4, 8'h01); rchk("R1", 4'd5, 8'h00);
        rchk("R1", 4'd6, 8'h00); rchk("R1", 4'd7, 8'h20); rchk("R1", 4'd8, 8'h01);

        // R8 locked write ignored
        wr(4'd0, 8'h30);
        rchk("R8", 4'd0, 8'h00);
        rchk("R8", 4'd8, 8'h01);
        // R9 guard sequence
        wr(4'd8, 8'h04);
        rchk("R9", 4'd8, 8'h01);
        wr(4'd8, 8'h02);
        rchk("R9", 4'd8, 8'h03);
        wr(4'd1, 8'h11);
        rchk("R8", 4'd1, 8'h00);
        wr(4'd8, 8'h06);
        rchk("R9", 4'd8, 8'h07);
        // R12 flags
        wr(4'd0, 8'h00);
        rchk("R12", 4'd8, 8'h06);
        @(negedge clk); osc_fail_i = 1'b1;
        @(negedge clk); osc_fail_i = 1'b0;
        rchk("R12", 4'd8, 8'h16);
        wr(4'd1, 8'h00);
        rchk("R12", 4'd8, 8'h06);

        // Vector table: load, one second, compare every field
        for (int v = 0; v < NVEC; v++) begin
            st = VEC[v][127:64];
            ex = VEC[v][63:0];
            for (int f = 7; f >= 0; f--)
                wr(4'(f), st[8*(7-f) +: 8]);
            ticks(TPS);
            for (int f = 0; f < 8; f++)
                rchk($sformatf("R3-7 vec%0d field%0d", v, f), 4'(f), ex[8*(7-f) +: 8]);
        end

        // R2 exact tick count
        wr(4'd0, 8'h20);
        ticks(TPS - 1);
        rchk("R2", 4'd0, 8'h20);
        ticks(1);
        rchk("R2", 4'd0, 8'h21);

        // R10 seconds write restarts the count
        ticks(2);
        wr(4'd0, 8'h40);
        ticks(TPS - 1);
        rchk("R10", 4'd0, 8'h40);
        ticks(1);
        rchk("R10", 4'd0, 8'h41);

        // R13 write on the step cycle cancels the step
        ticks(TPS - 1);
        @(negedge clk);
        tick_i = 1'b1; wr_en_i = 1'b1; addr_i = 4'd1; wdata_i = 8'h07;
        @(negedge clk);
        tick_i = 1'b0; wr_en_i = 1'b0;
        rchk("R13", 4'd0, 8'h41);
        rchk("R13", 4'd1, 8'h07);
        ticks(TPS);
        rchk("R13", 4'd0, 8'h42);

        // R11 masks and map
        wr(4'd2, 8'hD2); rchk("R11", 4'd2, 8'h92);
        wr(4'd3, 8'hE8); rchk("R11", 4'd3, 8'h28);
        wr(4'd4, 8'hF1); rchk("R11", 4'd4, 8'h11);
        wr(4'd0, 8'hD9); rchk("R11", 4'd0, 8'h59);
        wr(4'd6, 8'hFD); rchk("R11", 4'd6, 8'h05);
        rchk("R11", 4'd9, 8'h00);
        // R13 value-checked writes
        wr(4'd6, 8'h07); rchk("R13", 4'd6, 8'h05);
        wr(4'd7, 8'h19); rchk("R13", 4'd7, 8'h19);
        wr(4'd7, 8'h21); rchk("R13", 4'd7, 8'h19);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule